// File: doc/BRIEF.md
# BCD Calendar Clock Core

This block keeps wall-clock time and date as a set of byte registers. The fields are hundredths of a second, seconds, minutes, hours, weekday, day of month, month and a two-digit year, all in packed BCD. A free-running enable, `osc_tick`, advances an internal sub-second prescaler. Every `SUB_DIV` ticks the hundredths count steps by one, and carries ripple upward through the calendar. Month lengths and leap years are taken into account.

A host reaches the registers through a simple synchronous byte bus with an address, write data, write and read strobes, and a registered read port. For multi-byte transfers the host raises `bus_seq`, and the access then goes to the address after the previous one. The highest register wraps back to address zero. A single burst that starts at the run-control register can therefore halt the clock, clear the prescaler and load the whole time and date.

Further functions:
- a 12-hour display mode with a PM flag inside the hour register;
- a run/halt control;
- a keyed command that clears the prescaler;
- a sticky oscillator-stopped status flag that is set at reset and cleared by software.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset, the time reads 00:00:00.00 on day 01, month 01, year 00, weekday 0. The seconds register (0x01) reads 0x80 because its status bit 7 is set. The configuration register (0x25) and the run-control register (0x2E) read 0x00, so the clock starts in 24-hour mode and running.
- R2: The hundredths register (0x00) counts BCD 00..99 and advances once per `SUB_DIV` ticks. Its 99→00 wrap adds one to the seconds (bits 6:0 of 0x01). The seconds 59→00 wrap adds one to the minutes (0x02), and the minutes 59→00 wrap carries into the hour.
- R3: Bit 7 of 0x01 is a status flag that is independent of the BCD seconds in bits 6:0. Writing 0 to that bit clears the flag. Writing 1 leaves it unchanged, and after reset nothing sets it again.
- R4: When bit 5 of 0x25 is 0, the hour register (0x03) counts BCD 00..23. The wrap from 23 to 00 adds one to the day of month (0x04) and to the weekday (0x05), and the weekday wraps from 6 to 0.
- R5: When bit 5 of 0x25 is 1, the hour register holds BCD 1..12 in bits 4:0 with bit 5 as the PM flag. The count runs 0x11→0x32, 0x12→0x01 (PM kept), 0x32→0x21 and 0x31→0x12. Only 0x31→0x12 carries into the day and weekday.
- R6: The day of month wraps to 01 after day 30 in months 04, 06, 09 and 11. It wraps after day 29 in month 02 when the year value is divisible by 4, after day 28 in the other years, and after day 31 in the other months. The wrap adds one to the month (0x06). The month 12→01 wrap adds one to the year (0x07), and the year wraps from 99 to 00.
- R7: Writing 1 to bit 0 of 0x2E halts the prescaler and all counting. Writing 0 resumes counting from the same prescaler phase. The bit reads back in bit 0.
- R8: Writing 0xA4 to the command register (0x2F) zeroes the prescaler and the hundredths, and this clear takes priority over a tick in the same cycle. Writing any other value to 0x2F changes nothing, and 0x2F reads 0x00.
- R9: An access with `bus_seq` = 1 ignores `bus_addr` and uses the address after the previous access. The address after 0x2F is 0x00.
- R10: A host write to a time register is visible from the next cycle. It takes precedence over a carry or step into that field in the same cycle, and no carry leaves a field that is being written.
- R11: Read data appears on `bus_rdata` in the cycle after the read strobe and is then held. Register 0x25 stores bits 5:0 and reads bits 7:6 as 0. Unmapped addresses such as 0x10 read 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | Prescaler advance enable, `SUB_DIV` per hundredth |
| bus_addr | input | ADDR_W | Register address, used when `bus_seq` is 0 |
| bus_seq | input | 1 | Use the previous address plus one, wrapping 0x2F to 0x00 |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |

## Verification
The bench builds the block with `SUB_DIV` = 2 and the default 6-bit address. One hundredth then costs two ticks, so an unbroken run from reset across a full minute, and every step in it, fits in the cycle budget. Hour, day, month and year rollovers are reached by preloading each case through a wrapping burst just before its edge. This covers all 24 hours in both hour modes, every year value for February, and each month in leap, common and final years. Cycle-exact collisions between a tick, a key write and a field write are staged by first stepping the prescaler to its last phase.

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock #(
  parameter int SUB_DIV = 4,
  parameter int ADDR_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_seq,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata
);
  localparam int PRE_W = (SUB_DIV > 1) ? $clog2(SUB_DIV) : 1;
  localparam logic [PRE_W-1:0]  PRE_MAX = PRE_W'(SUB_DIV - 1);
  localparam logic [ADDR_W-1:0] A_HS   = 'h00;
  localparam logic [ADDR_W-1:0] A_SEC  = 'h01;
  localparam logic [ADDR_W-1:0] A_MIN  = 'h02;
  localparam logic [ADDR_W-1:0] A_HR   = 'h03;
  localparam logic [ADDR_W-1:0] A_DAY  = 'h04;
  localparam logic [ADDR_W-1:0] A_WD   = 'h05;
  localparam logic [ADDR_W-1:0] A_MON  = 'h06;
  localparam logic [ADDR_W-1:0] A_YR   = 'h07;
  localparam logic [ADDR_W-1:0] A_CFG  = 'h25;
  localparam logic [ADDR_W-1:0] A_RUN  = 'h2E;
  localparam logic [ADDR_W-1:0] A_CMD  = 'h2F;
  localparam logic [7:0]        CLR_KEY = 8'hA4;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [5:0] last_day(input logic [4:0] m, input logic [7:0] y);
    logic leap;
    leap = y[4] ? (y[1:0] == 2'b10) : (y[1:0] == 2'b00);
    case (m)
      5'h02:                      return leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

  function automatic logic [5:0] hr_next(input logic [5:0] h, input logic m12);
    logic [7:0] t;
    if (!m12) begin
      t = bcd_inc({2'b00, h});
      return (h == 6'h23) ? 6'h00 : t[5:0];
    end
    t = bcd_inc({3'b000, h[4:0]});
    if (h[4:0] == 5'h11) return {~h[5], 5'h12};
    if (h[4:0] == 5'h12) return {h[5], 5'h01};
    return {h[5], t[4:0]};
  endfunction

  logic [PRE_W-1:0]  pre_q;
  logic [7:0]        hs_q, yr_q;
  logic [6:0]        sec_q, min_q;
  logic [5:0]        hr_q, day_q;
  logic [4:0]        mon_q, cfg_q;
  logic [2:0]        wd_q;
  logic              osf_q, h12_q, halt_q;
  logic [ADDR_W-1:0] ptr_q, eff;

  logic w_hs, w_sec, w_min, w_hr, w_day, w_wd, w_mon, w_yr, w_cfg, w_run;
  logic clr, run, step, hr_last;
  logic c_sec, c_min, c_hr, c_day, c_mon, c_yr;
  logic [7:0] sec_i, min_i, day_i, mon_i;

  assign eff   = bus_seq ? ((ptr_q == A_CMD) ? '0 : ptr_q + ADDR_W'(1)) : bus_addr;
  assign w_hs  = bus_wr && (eff == A_HS);
  assign w_sec = bus_wr && (eff == A_SEC);
  assign w_min = bus_wr && (eff == A_MIN);
  assign w_hr  = bus_wr && (eff == A_HR);
  assign w_day = bus_wr && (eff == A_DAY);
  assign w_wd  = bus_wr && (eff == A_WD);
  assign w_mon = bus_wr && (eff == A_MON);
  assign w_yr  = bus_wr && (eff == A_YR);
  assign w_cfg = bus_wr && (eff == A_CFG);
  assign w_run = bus_wr && (eff == A_RUN);
  assign clr   = bus_wr && (eff == A_CMD) && (bus_wdata == CLR_KEY);

  assign run     = osc_tick && !halt_q && !clr;
  assign step    = run && (pre_q == PRE_MAX);
  assign hr_last = h12_q ? (hr_q == 6'h31) : (hr_q == 6'h23);
  assign c_sec   = step  && (hs_q == 8'h99) && !w_hs;
  assign c_min   = c_sec && (sec_q == 7'h59) && !w_sec;
  assign c_hr    = c_min && (min_q == 7'h59) && !w_min;
  assign c_day   = c_hr  && hr_last && !w_hr;
  assign c_mon   = c_day && (day_q >= last_day(mon_q, yr_q)) && !w_day;
  assign c_yr    = c_mon && (mon_q >= 5'h12) && !w_mon;

  assign sec_i = bcd_inc({1'b0, sec_q});
  assign min_i = bcd_inc({1'b0, min_q});
  assign day_i = bcd_inc({2'b00, day_q});
  assign mon_i = bcd_inc({3'b000, mon_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      hs_q   <= 8'h00;
      sec_q  <= 7'h00;
      osf_q  <= 1'b1;
      min_q  <= 7'h00;
      hr_q   <= 6'h00;
      day_q  <= 6'h01;
      wd_q   <= 3'd0;
      mon_q  <= 5'h01;
      yr_q   <= 8'h00;
      cfg_q  <= 5'h00;
      h12_q  <= 1'b0;
      halt_q <= 1'b0;
      ptr_q  <= '0;
    end else begin
      if (bus_wr || bus_rd) ptr_q <= eff;

      if (clr)      pre_q <= '0;
      else if (run) pre_q <= (pre_q == PRE_MAX) ? '0 : pre_q + PRE_W'(1);

      if (w_hs)      hs_q <= bus_wdata;
      else if (clr)  hs_q <= 8'h00;
      else if (step) hs_q <= (hs_q == 8'h99) ? 8'h00 : bcd_inc(hs_q);

      if (w_sec) begin
        sec_q <= bus_wdata[6:0];
        osf_q <= osf_q & bus_wdata[7];
      end else if (c_sec) begin
        sec_q <= (sec_q == 7'h59) ? 7'h00 : sec_i[6:0];
      end

      if (w_min)      min_q <= bus_wdata[6:0];
      else if (c_min) min_q <= (min_q == 7'h59) ? 7'h00 : min_i[6:0];

      if (w_hr)      hr_q <= bus_wdata[5:0];
      else if (c_hr) hr_q <= hr_next(hr_q, h12_q);

      if (w_day)       day_q <= bus_wdata[5:0];
      else if (c_day)  day_q <= c_mon ? 6'h01 : day_i[5:0];

      if (w_wd)        wd_q <= bus_wdata[2:0];
      else if (c_day)  wd_q <= (wd_q >= 3'd6) ? 3'd0 : wd_q + 3'd1;

      if (w_mon)       mon_q <= bus_wdata[4:0];
      else if (c_mon)  mon_q <= c_yr ? 5'h01 : mon_i[4:0];

      if (w_yr)        yr_q <= bus_wdata;
      else if (c_yr)   yr_q <= (yr_q == 8'h99) ? 8'h00 : bcd_inc(yr_q);

      if (w_cfg) begin
        cfg_q <= bus_wdata[4:0];
        h12_q <= bus_wdata[5];
      end
      if (w_run) halt_q <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= 8'h00;
    else if (bus_rd) begin
      case (eff)
        A_HS:    bus_rdata <= hs_q;
        A_SEC:   bus_rdata <= {osf_q, sec_q};
        A_MIN:   bus_rdata <= {1'b0, min_q};
        A_HR:    bus_rdata <= {2'b00, hr_q};
        A_DAY:   bus_rdata <= {2'b00, day_q};
        A_WD:    bus_rdata <= {5'b00000, wd_q};
        A_MON:   bus_rdata <= {3'b000, mon_q};
        A_YR:    bus_rdata <= yr_q;
        A_CFG:   bus_rdata <= {2'b00, h12_q, cfg_q};
        A_RUN:   bus_rdata <= {7'b0000000, halt_q};
        default: bus_rdata <= 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/bcd_calendar_clock_chk.sv
module bcd_calendar_clock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic [7:0] hs,
  input logic [6:0] sec,
  input logic       osf,
  input logic [5:0] day,
  input logic [2:0] wd,
  input logic       halt
);
  p_osf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (osf == 1'b0) |=> (osf == 1'b0));

  p_sec_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && hs == 8'h99) |=> ((hs == 8'h00) == (sec != $past(sec))));

  p_hs_digits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hs[3:0] <= 4'd9) && (hs[7:4] <= 4'd9));

  p_halt_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !bus_wr) |=> ($stable(hs) && $stable(sec)));

  p_wday_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wd <= 3'd6);

  p_day_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    day != 6'h00);
endmodule

bind bcd_calendar_clock bcd_calendar_clock_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .hs(hs_q), .sec(sec_q),
  .osf(osf_q), .day(day_q), .wd(wd_q), .halt(halt_q)
);

// File: tb/bcd_calendar_clock_tb.sv
module bcd_calendar_clock_tb_top;
  localparam int SUB = 2;

  logic       clk = 1'b0, rst_n = 1'b0, osc_tick = 1'b0;
  logic       bus_seq = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bcd_calendar_clock #(.SUB_DIV(SUB), .ADDR_W(6)) dut_i (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .bus_addr(bus_addr),
    .bus_seq(bus_seq), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata)
  );

  function automatic logic [7:0] bcd(input int n);
    return 8'(((n / 10) % 10) * 16 + n % 10);
  endfunction

  function automatic logic [7:0] enc12(input int h);
    int h12;
    h12 = h % 12;
    if (h12 == 0) h12 = 12;
    return bcd(h12) | ((h >= 12) ? 8'h20 : 8'h00);
  endfunction

  function automatic int mdays(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d, input bit sq);
    bus_addr = a; bus_wdata = d; bus_seq = sq; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_seq = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input bit sq, output logic [7:0] v);
    bus_addr = a; bus_seq = sq; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; bus_seq = 1'b0;
    v = bus_rdata;
  endtask

  task automatic tick(input int n);
    osc_tick = 1'b1;
    repeat (n) @(negedge clk);
    osc_tick = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] hs, sc, mn, hr, dy, wd, mo, yr);
    wr(6'h2E, 8'h00, 1'b0);
    wr(6'h3F, 8'hA4, 1'b1);
    wr(6'h3F, hs, 1'b1);
    wr(6'h3F, sc, 1'b1);
    wr(6'h3F, mn, 1'b1);
    wr(6'h3F, hr, 1'b1);
    wr(6'h3F, dy, 1'b1);
    wr(6'h3F, wd, 1'b1);
    wr(6'h3F, mo, 1'b1);
    wr(6'h3F, yr, 1'b1);
  endtask

  task automatic expect_reg(input string tag, input logic [5:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, 1'b0, v);
    chk(tag, v, exp);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    expect_reg("R1 hs", 6'h00, 8'h00);
    expect_reg("R1 sec", 6'h01, 8'h80);
    expect_reg("R1 min", 6'h02, 8'h00);
    expect_reg("R1 hr", 6'h03, 8'h00);
    expect_reg("R1 day", 6'h04, 8'h01);
    expect_reg("R1 wd", 6'h05, 8'h00);
    expect_reg("R1 mon", 6'h06, 8'h01);
    expect_reg("R1 yr", 6'h07, 8'h00);
    expect_reg("R1 cfg", 6'h25, 8'h00);
    expect_reg("R1 run", 6'h2E, 8'h00);

    // R2 continuous count across a minute, status bit kept (R3)
    for (int i = 1; i <= 6100; i++) begin
      tick(SUB);
      expect_reg("R2 hs", 6'h00, bcd(i % 100));
      expect_reg("R2 R3 sec", 6'h01, 8'h80 | bcd((i / 100) % 60));
      if (i % 100 == 0) expect_reg("R2 min", 6'h02, bcd(i / 6000));
    end

    // R3 status flag writes
    wr(6'h01, 8'hD5, 1'b0);
    expect_reg("R3 keep", 6'h01, 8'hD5);
    wr(6'h01, 8'h15, 1'b0);
    expect_reg("R3 clear", 6'h01, 8'h15);
    wr(6'h01, 8'h95, 1'b0);
    expect_reg("R3 noset", 6'h01, 8'h15);

    // R4 24-hour sweep
    for (int h = 0; h < 24; h++) begin
      set_time(8'h99, 8'h59, 8'h59, bcd(h), 8'h15, 8'(h % 7), 8'h03, 8'h21);
      tick(SUB);
      expect_reg("R4 hr", 6'h03, bcd((h + 1) % 24));
      expect_reg("R4 min", 6'h02, 8'h00);
      expect_reg("R4 day", 6'h04, (h == 23) ? 8'h16 : 8'h15);
      expect_reg("R4 wd", 6'h05, 8'((h == 23) ? ((h % 7) + 1) % 7 : h % 7));
    end

    // R5 12-hour sweep
    wr(6'h25, 8'h20, 1'b0);
    for (int h = 0; h < 24; h++) begin
      set_time(8'h99, 8'h59, 8'h59, enc12(h), 8'h15, 8'h06, 8'h03, 8'h21);
      tick(SUB);
      expect_reg("R5 hr", 6'h03, enc12((h + 1) % 24));
      expect_reg("R5 day", 6'h04, (h == 23) ? 8'h16 : 8'h15);
      expect_reg("R5 wd", 6'h05, (h == 23) ? 8'h00 : 8'h06);
    end
    wr(6'h25, 8'h00, 1'b0);

    // R6 February over every year value
    for (int y = 0; y < 100; y++) begin
      set_time(8'h99, 8'h59, 8'h59, 8'h23, 8'h28, 8'h01, 8'h02, bcd(y));
      tick(SUB);
      expect_reg("R6 feb day", 6'h04, (y % 4 == 0) ? 8'h29 : 8'h01);
      expect_reg("R6 feb mon", 6'h06, (y % 4 == 0) ? 8'h02 : 8'h03);
    end

    // R6 month ends in common, leap and final years
    for (int k = 0; k < 3; k++) begin
      int y;
      y = (k == 0) ? 3 : (k == 1) ? 4 : 99;
      for (int m = 1; m <= 12; m++) begin
        set_time(8'h99, 8'h59, 8'h59, 8'h23, bcd(mdays(m, y) - 1), 8'h02, bcd(m), bcd(y));
        tick(SUB);
        expect_reg("R6 early day", 6'h04, bcd(mdays(m, y)));
        set_time(8'h99, 8'h59, 8'h59, 8'h23, bcd(mdays(m, y)), 8'h06, bcd(m), bcd(y));
        tick(SUB);
        expect_reg("R6 day", 6'h04, 8'h01);
        expect_reg("R6 mon", 6'h06, bcd(m % 12 + 1));
        expect_reg("R6 yr", 6'h07, (m == 12) ? bcd((y + 1) % 100) : bcd(y));
        expect_reg("R6 wd", 6'h05, 8'h00);
      end
    end

    // R7 halt and resume
    set_time(8'h10, 8'h05, 8'h00, 8'h01, 8'h01, 8'h00, 8'h01, 8'h00);
    wr(6'h2E, 8'h01, 1'b0);
    tick(10);
    expect_reg("R7 frozen", 6'h00, 8'h10);
    expect_reg("R7 readback", 6'h2E, 8'h01);
    wr(6'h2E, 8'h00, 1'b0);
    tick(2 * SUB);
    expect_reg("R7 resumed", 6'h00, 8'h12);

    // R8 keyed prescaler clear
    set_time(8'h20, 8'h05, 8'h00, 8'h01, 8'h01, 8'h00, 8'h01, 8'h00);
    tick(1);
    wr(6'h2F, 8'h55, 1'b0);
    tick(1);
    expect_reg("R8 wrong key", 6'h00, 8'h21);
    tick(1);
    bus_addr = 6'h2F; bus_wdata = 8'hA4; bus_wr = 1'b1; osc_tick = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; osc_tick = 1'b0;
    expect_reg("R8 clear", 6'h00, 8'h00);
    tick(1);
    expect_reg("R8 phase zero", 6'h00, 8'h00);
    tick(1);
    expect_reg("R8 phase restart", 6'h00, 8'h01);
    expect_reg("R8 read", 6'h2F, 8'h00);

    // R9 burst read with wrap
    set_time(8'h33, 8'h44, 8'h55, 8'h12, 8'h09, 8'h03, 8'h07, 8'h42);
    expect_reg("R9 start", 6'h2E, 8'h00);
    rd(6'h3F, 1'b1, v); chk("R9 cmd", v, 8'h00);
    rd(6'h3F, 1'b1, v); chk("R9 wrap hs", v, 8'h33);
    rd(6'h3F, 1'b1, v); chk("R9 sec", v, 8'h44);
    rd(6'h3F, 1'b1, v); chk("R9 min", v, 8'h55);
    rd(6'h3F, 1'b1, v); chk("R9 hr", v, 8'h12);
    rd(6'h3F, 1'b1, v); chk("R9 day", v, 8'h09);
    rd(6'h3F, 1'b1, v); chk("R9 wd", v, 8'h03);
    rd(6'h3F, 1'b1, v); chk("R9 mon", v, 8'h07);
    rd(6'h3F, 1'b1, v); chk("R9 yr", v, 8'h42);

    // R10 write beats a same-cycle carry
    set_time(8'h99, 8'h10, 8'h20, 8'h01, 8'h01, 8'h00, 8'h01, 8'h00);
    tick(1);
    bus_addr = 6'h01; bus_wdata = 8'h30; bus_wr = 1'b1; osc_tick = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; osc_tick = 1'b0;
    expect_reg("R10 hs stepped", 6'h00, 8'h00);
    expect_reg("R10 sec written", 6'h01, 8'h30);
    expect_reg("R10 min kept", 6'h02, 8'h20);
    tick(1);
    bus_addr = 6'h00; bus_wdata = 8'h42; bus_wr = 1'b1; osc_tick = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; osc_tick = 1'b0;
    expect_reg("R10 hs written", 6'h00, 8'h42);
    expect_reg("R10 sec kept", 6'h01, 8'h30);

    // R11 configuration storage and unmapped space
    wr(6'h25, 8'hDF, 1'b0);
    expect_reg("R11 cfg low", 6'h25, 8'h1F);
    wr(6'h25, 8'hFF, 1'b0);
    expect_reg("R11 cfg all", 6'h25, 8'h3F);
    wr(6'h25, 8'h00, 1'b0);
    wr(6'h10, 8'hFF, 1'b0);
    expect_reg("R11 unmapped", 6'h10, 8'h00);
    expect_reg("R11 hs untouched", 6'h00, 8'h42);
    expect_reg("R11 run untouched", 6'h2E, 8'h00);
    @(negedge clk);
    chk("R11 hold", bus_rdata, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule